// File: doc/BRIEF.md
# Ethernet Transmit Frame Encapsulator

This block turns the bytes of an outgoing packet, held in a byte FIFO, into one complete serial Ethernet frame. It waits until the FIFO holds enough bytes and the medium may be used. It then sends the preamble and start delimiter and shifts out the user bytes. A short frame can be filled with zero bytes. A CRC-32 frame check sequence can be added at the end. The output is one bit per clock, qualified by a transmit-enable strobe.

The FIFO is read as a show-ahead queue: the head byte and its end-of-packet flag are visible at the inputs, and a one-cycle pop strobe consumes it. The padding and checksum choices are sampled once, when a frame starts. Each packet can therefore use its own settings, and changes made while a frame is on the wire do not affect that frame. Collision handling, backoff, line coding and host access are handled elsewhere.

Top module: `eth_tx_encap`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `tx_en` is 0, `tx_bit` is 0 and `fifo_pop` is 0.
- R2: A frame starts only when `chan_ok` is 1, `fifo_level` is at least 1 and `fifo_level >= start_thresh`. If the start condition is seen at one rising edge, `tx_en` goes high after the second rising edge that follows. Otherwise `tx_en` stays 0.
- R3: Each frame opens with 64 bits: 62 bits alternating 1,0,1,0,… (first bit 1), then 1,1. These form seven 0x55 preamble octets and one 0xD5 delimiter octet, each sent least significant bit first.
- R4: The user bytes follow in FIFO order, each sent least significant bit first. One byte is popped per octet, and no byte is popped outside a frame.
- R5: With padding enabled, 0x00 bytes follow the user bytes until the data portion (user bytes plus pad) is 60 bytes. A packet of 60 or more bytes gets no pad.
- R6: With padding disabled, a short packet is sent with exactly its own bytes.
- R7: With the checksum enabled, 32 FCS bits follow the data portion. The FCS is the complement of the CRC-32 (polynomial 0x04C11DB7, preset to all ones) over the data portion bits in the order they are sent, excluding preamble and delimiter. It is sent from the x^31 term first.
- R8: With the checksum disabled, the frame ends right after the data portion. Padding, if enabled, still brings the data portion to 60 bytes.
- R9: `tx_en` stays high for the whole frame: 64 + 8·D (+32 with FCS) cycles, where D is the number of data-portion bytes. It falls on the clock after the last bit. `tx_bit` is 0 whenever `tx_en` is 0.
- R10: `pad_en` and `fcs_en` are sampled when a frame starts. Changing them during the frame does not change that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fifo_data | input | 8 | Head byte of the transmit FIFO |
| fifo_last | input | 1 | Head byte is the last byte of its packet |
| fifo_level | input | LVL_W | Number of bytes in the FIFO |
| fifo_pop | output | 1 | Consume the head byte this cycle |
| start_thresh | input | LVL_W | Fill level needed to start a frame |
| chan_ok | input | 1 | Medium may be used now |
| pad_en | input | 1 | Pad short frames with zero bytes |
| fcs_en | input | 1 | Append the CRC-32 check sequence |
| tx_bit | output | 1 | Serial frame bit |
| tx_en | output | 1 | Frame bit valid |

## Verification
The sensitive coincidence is the octet on which the last user byte ends and the pad-length target is met. In that single cycle the controller must pick between more padding, the checksum and the end of the frame. The bench sends packets of 59, 60 and 61 bytes, with and without checksum. It rebuilds each whole frame independently, using a reflected CRC formulation, and compares every bit and the frame length. A second coincidence is an enable changing in the same cycles as the frame runs: the bench toggles both enables just after `tx_en` rises and expects the frame that was set up at the start.

// File: rtl/eth_tx_pkg.sv
`timescale 1ns/1ps
package eth_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_DATA,
    ST_PAD,
    ST_FCS
  } tx_state_e;

  localparam int OCTET = 8;
endpackage

// File: rtl/eth_tx_crc.sv
`timescale 1ns/1ps
// CRC generator: absorbs serial bits while updating, then shifts out its
// complemented contents, highest term first.
module eth_tx_crc #(
  parameter int          W    = 32,
  parameter logic [W-1:0] POLY = 32'h04C11DB7
) (
  input  logic clk,
  input  logic rst,
  input  logic init,
  input  logic upd,
  input  logic din,
  input  logic drain,
  output logic fcs_bit
);
  logic [W-1:0] crc_q;
  logic         fb;

  assign fb      = crc_q[W-1] ^ din;
  assign fcs_bit = ~crc_q[W-1];

  always_ff @(posedge clk) begin
    if (rst || init) begin
      crc_q <= '1;
    end else if (upd) begin
      crc_q <= {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end else if (drain) begin
      crc_q <= {crc_q[W-2:0], 1'b1};
    end
  end
endmodule

// File: rtl/eth_tx_shifter.sv
`timescale 1ns/1ps
// Byte serializer, least significant bit first.
module eth_tx_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] din,
  input  logic          shift,
  output logic          dout
);
  logic [DW-1:0] sh_q;

  assign dout = sh_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '0;
    end else if (load) begin
      sh_q <= din;
    end else if (shift) begin
      sh_q <= {1'b0, sh_q[DW-1:1]};
    end
  end
endmodule

// File: rtl/eth_tx_ctrl.sv
`timescale 1ns/1ps
// Frame sequencer: start decision, phase counters, pad sizing.
module eth_tx_ctrl
  import eth_tx_pkg::*;
#(
  parameter int LVL_W    = 8,
  parameter int PRE_BITS = 64,
  parameter int FCS_BITS = 32,
  parameter int MIN_DATA = 60,
  parameter int LEN_W    = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic [LVL_W-1:0] start_thresh,
  input  logic             chan_ok,
  input  logic             pad_en,
  input  logic             fcs_en,
  input  logic             fifo_last,
  output tx_state_e        state,
  output logic             pre_bit,
  output logic             pop
);
  localparam int CNT_W = (PRE_BITS > FCS_BITS) ? $clog2(PRE_BITS) : $clog2(FCS_BITS);
  localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(PRE_BITS - 1);
  localparam logic [CNT_W-1:0] FCS_LAST = CNT_W'(FCS_BITS - 1);
  localparam logic [CNT_W-1:0] OCT_LAST = CNT_W'(OCTET - 1);

  tx_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [LEN_W-1:0] byte_q;
  logic [LEN_W-1:0] byte_inc;
  logic             pad_q, fcs_q, last_q;
  logic             start, byte_end, pad_more;

  assign state    = state_q;
  assign start    = (state_q == ST_IDLE) && chan_ok && (fifo_level != '0) &&
                    (fifo_level >= start_thresh);
  assign byte_end = (cnt_q == OCT_LAST);
  assign byte_inc = (byte_q == '1) ? byte_q : byte_q + 1'b1;
  assign pad_more = pad_q && (byte_inc < LEN_W'(MIN_DATA));
  assign pre_bit  = (cnt_q == PRE_LAST) ? 1'b1 : ~cnt_q[0];
  assign pop      = ((state_q == ST_PRE)  && (cnt_q == PRE_LAST)) ||
                    ((state_q == ST_DATA) && byte_end && !last_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      byte_q  <= '0;
      pad_q   <= 1'b0;
      fcs_q   <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (start) begin
            state_q <= ST_PRE;
            pad_q   <= pad_en;
            fcs_q   <= fcs_en;
          end
        end
        ST_PRE: begin
          if (cnt_q == PRE_LAST) begin
            state_q <= ST_DATA;
            cnt_q   <= '0;
            byte_q  <= '0;
            last_q  <= fifo_last;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DATA: begin
          if (byte_end) begin
            cnt_q  <= '0;
            byte_q <= byte_inc;
            if (!last_q)       last_q  <= fifo_last;
            else if (pad_more) state_q <= ST_PAD;
            else if (fcs_q)    state_q <= ST_FCS;
            else               state_q <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_PAD: begin
          if (byte_end) begin
            cnt_q  <= '0;
            byte_q <= byte_inc;
            if (!pad_more) state_q <= fcs_q ? ST_FCS : ST_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_FCS: begin
          if (cnt_q == FCS_LAST) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eth_tx_encap.sv
`timescale 1ns/1ps
module eth_tx_encap
  import eth_tx_pkg::*;
#(
  parameter int LVL_W     = 8,
  parameter int PRE_BYTES = 7,
  parameter int MIN_FRAME = 64,
  parameter int FCS_BYTES = 4,
  parameter int LEN_W     = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       fifo_data,
  input  logic             fifo_last,
  input  logic [LVL_W-1:0] fifo_level,
  output logic             fifo_pop,
  input  logic [LVL_W-1:0] start_thresh,
  input  logic             chan_ok,
  input  logic             pad_en,
  input  logic             fcs_en,
  output logic             tx_bit,
  output logic             tx_en
);
  localparam int PRE_BITS = (PRE_BYTES + 1) * OCTET;
  localparam int FCS_BITS = FCS_BYTES * OCTET;
  localparam int MIN_DATA = MIN_FRAME - FCS_BYTES;

  tx_state_e state;
  logic      pre_bit, data_bit, fcs_bit, cur_bit, active;

  eth_tx_ctrl #(
    .LVL_W(LVL_W), .PRE_BITS(PRE_BITS), .FCS_BITS(FCS_BITS),
    .MIN_DATA(MIN_DATA), .LEN_W(LEN_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .fifo_level(fifo_level), .start_thresh(start_thresh),
    .chan_ok(chan_ok), .pad_en(pad_en), .fcs_en(fcs_en), .fifo_last(fifo_last),
    .state(state), .pre_bit(pre_bit), .pop(fifo_pop)
  );

  eth_tx_shifter #(.DW(OCTET)) u_shift (
    .clk(clk), .rst(rst), .load(fifo_pop), .din(fifo_data),
    .shift(state == ST_DATA), .dout(data_bit)
  );

  eth_tx_crc #(.W(FCS_BITS)) u_crc (
    .clk(clk), .rst(rst), .init(state == ST_IDLE),
    .upd((state == ST_DATA) || (state == ST_PAD)), .din(cur_bit),
    .drain(state == ST_FCS), .fcs_bit(fcs_bit)
  );

  assign active = (state != ST_IDLE);

  always_comb begin
    case (state)
      ST_PRE:  cur_bit = pre_bit;
      ST_DATA: cur_bit = data_bit;
      ST_FCS:  cur_bit = fcs_bit;
      default: cur_bit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_en  <= 1'b0;
      tx_bit <= 1'b0;
    end else begin
      tx_en  <= active;
      tx_bit <= active & cur_bit;
    end
  end
endmodule

// File: rtl/eth_tx_encap_chk.sv
`timescale 1ns/1ps
module eth_tx_encap_chk #(
  parameter int LVL_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [LVL_W-1:0] fifo_level,
  input logic [LVL_W-1:0] start_thresh,
  input logic             chan_ok,
  input logic             fifo_pop,
  input logic             tx_bit,
  input logic             tx_en
);
  logic [15:0] run_len;

  always_ff @(posedge clk) begin
    if (rst)        run_len <= '0;
    else if (tx_en) run_len <= run_len + 1'b1;
    else            run_len <= '0;
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!tx_en && !fifo_pop));

  a_r2_start_cond: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_en) |-> ($past(chan_ok, 2) && ($past(fifo_level, 2) != '0) &&
                      ($past(fifo_level, 2) >= $past(start_thresh, 2))));

  a_r3_first_bit_one: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_en) |-> tx_bit);

  a_r4_pop_in_frame: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> tx_en);

  a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !tx_en |-> !tx_bit);

  a_r9_whole_octets: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_en) |-> (run_len[2:0] == 3'd0));
endmodule

bind eth_tx_encap eth_tx_encap_chk #(.LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst(rst), .fifo_level(fifo_level), .start_thresh(start_thresh),
  .chan_ok(chan_ok), .fifo_pop(fifo_pop), .tx_bit(tx_bit), .tx_en(tx_en)
);

// File: tb/eth_tx_encap_tb.sv
`timescale 1ns/1ps
module eth_tx_encap_tb;
  localparam int LVL_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [7:0]       fifo_data;
  logic             fifo_last;
  logic [LVL_W-1:0] fifo_level;
  logic             fifo_pop;
  logic [LVL_W-1:0] start_thresh = '0;
  logic             chan_ok = 1'b0;
  logic             pad_en = 1'b1;
  logic             fcs_en = 1'b1;
  logic             tx_bit, tx_en;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  eth_tx_encap #(.LVL_W(LVL_W)) u_dut (
    .clk(clk), .rst(rst), .fifo_data(fifo_data), .fifo_last(fifo_last),
    .fifo_level(fifo_level), .fifo_pop(fifo_pop), .start_thresh(start_thresh),
    .chan_ok(chan_ok), .pad_en(pad_en), .fcs_en(fcs_en),
    .tx_bit(tx_bit), .tx_en(tx_en)
  );

  // FIFO model, show-ahead
  logic [7:0] mem_d [256];
  logic       mem_l [256];
  logic [7:0] wp = '0;
  logic [7:0] rp = '0;
  assign fifo_level = wp - rp;
  assign fifo_data  = mem_d[rp];
  assign fifo_last  = mem_l[rp];
  always @(posedge clk) if (fifo_pop) rp <= rp + 8'd1;

  // frame capture
  logic cap [4096];
  int   cap_n = 0;
  always @(negedge clk) if (tx_en) begin
    if (cap_n < 4096) cap[cap_n] = tx_bit;
    cap_n++;
  end

  logic [7:0] pay [256];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b, input bit last);
    @(negedge clk);
    mem_d[wp] = b;
    mem_l[wp] = last;
    wp = wp + 8'd1;
  endtask

  task automatic fill(input int n, input int seed);
    for (int i = 0; i < n; i++) pay[i] = 8'((seed * 29) + (i * 13) + (i >> 3) + 1);
  endtask

  // compare captured frame with an independently rebuilt one
  task automatic judge(input int n, input bit pad, input bit fcs, input string tag);
    int           d, total, bad, k;
    logic [31:0]  c;
    logic         b, e;
    d     = (pad && n < 60) ? 60 : n;
    total = 64 + 8 * d + (fcs ? 32 : 0);
    chk(cap_n == total, {tag, " R9 frame length"}, cap_n, total);
    bad = 0;
    for (int i = 0; i < 64; i++) begin
      e = (i == 63) ? 1'b1 : ((i % 2) == 0);
      if (i < cap_n && cap[i] !== e) bad++;
    end
    chk(bad == 0, "R3 preamble/delimiter mismatched bits", bad, 0);
    bad = 0;
    c   = 32'hFFFF_FFFF;
    k   = 64;
    for (int j = 0; j < d; j++) begin
      for (int t = 0; t < 8; t++) begin
        b = (j < n) ? pay[j][t] : 1'b0;
        if (k < cap_n && cap[k] !== b) bad++;
        c = (c[0] ^ b) ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
        k++;
      end
    end
    chk(bad == 0, {tag, " R4 data portion mismatched bits"}, bad, 0);
    if (fcs) begin
      c   = ~c;
      bad = 0;
      for (int t = 0; t < 32; t++) begin
        if (k < cap_n && cap[k] !== c[t]) bad++;
        k++;
      end
      chk(bad == 0, {tag, " R7 FCS mismatched bits"}, bad, 0);
    end
  endtask

  task automatic wait_frame(input bit flip, output bit started);
    int w = 0;
    while (!tx_en && w < 100) begin @(negedge clk); w++; end
    started = tx_en;
    if (flip) begin pad_en = ~pad_en; fcs_en = ~fcs_en; end
    w = 0;
    while (tx_en && w < 20000) begin @(negedge clk); w++; end
    chk(tx_bit == 1'b0, "R9 idle bit after frame", tx_bit, 0);
  endtask

  task automatic run_frame(input int n, input int seed, input bit pad, input bit fcs,
                           input bit flip, input string tag);
    bit st;
    fill(n, seed);
    pad_en = pad; fcs_en = fcs; start_thresh = LVL_W'(n); chan_ok = 1'b1;
    cap_n = 0;
    for (int i = 0; i < n; i++) push(pay[i], i == n - 1);
    wait_frame(flip, st);
    chk(st, {tag, " R2 frame started"}, st, 1);
    judge(n, pad, fcs, tag);
  endtask

  task automatic test_reset();
    repeat (4) @(negedge clk);
    chk(!tx_en && !tx_bit && !fifo_pop, "R1 outputs quiet in reset", {tx_en, tx_bit, fifo_pop}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!tx_en && !tx_bit && !fifo_pop, "R1 outputs quiet after reset", {tx_en, tx_bit, fifo_pop}, 0);
  endtask

  task automatic test_threshold();
    bit st;
    start_thresh = '0; chan_ok = 1'b1; pad_en = 1'b1; fcs_en = 1'b1;
    repeat (10) @(negedge clk);
    chk(!tx_en, "R2 empty FIFO with zero threshold", tx_en, 0);
    fill(12, 3);
    start_thresh = 8'd10; cap_n = 0;
    for (int i = 0; i < 5; i++) push(pay[i], 1'b0);
    repeat (20) @(negedge clk);
    chk(!tx_en, "R2 below threshold", tx_en, 0);
    chan_ok = 1'b0;
    for (int i = 5; i < 12; i++) push(pay[i], i == 11);
    repeat (10) @(negedge clk);
    chk(!tx_en, "R2 channel not permitted", tx_en, 0);
    chan_ok = 1'b1;
    @(negedge clk);
    chk(!tx_en, "R2 latency first edge", tx_en, 0);
    @(negedge clk);
    chk(tx_en, "R2 latency second edge", tx_en, 1);
    wait_frame(1'b0, st);
    judge(12, 1'b1, 1'b1, "R5 12-byte padded");
  endtask

  task automatic test_pad_boundary();
    run_frame(59, 5, 1'b1, 1'b1, 1'b0, "R5 59 bytes");
    run_frame(60, 6, 1'b1, 1'b1, 1'b0, "R5 60 bytes");
    run_frame(61, 7, 1'b1, 1'b1, 1'b0, "R5 61 bytes");
    run_frame(60, 8, 1'b1, 1'b0, 1'b0, "R8 60 bytes no FCS");
  endtask

  task automatic test_long();
    run_frame(100, 9, 1'b1, 1'b1, 1'b0, "R4 100 bytes");
  endtask

  task automatic test_nopad();
    run_frame(20, 11, 1'b0, 1'b1, 1'b0, "R6 20 bytes unpadded");
  endtask

  task automatic test_nofcs();
    run_frame(20, 12, 1'b1, 1'b0, 1'b0, "R8 20 bytes padded no FCS");
    run_frame(7, 13, 1'b0, 1'b0, 1'b0, "R8 7 bytes bare");
  endtask

  task automatic test_latch();
    run_frame(10, 14, 1'b1, 1'b1, 1'b1, "R10 enables toggled mid-frame");
    run_frame(10, 15, 1'b0, 1'b0, 1'b1, "R10 enables raised mid-frame");
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin mem_d[i] = '0; mem_l[i] = 1'b0; end
    test_reset();
    test_threshold();
    test_pad_boundary();
    test_long();
    test_nopad();
    test_nofcs();
    test_latch();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule